// File: doc/BRIEF.md
# Coupling Coefficient Refresh and Perturbation Controller

This block is the digital front end of an analog all-to-all coupling array. It keeps a square table of signed coupling coefficients (sign plus 4-bit magnitude, so 31 usable levels from -15 to +15) in flop-based storage. After a start pulse it streams the table out one column at a time over a serial shift link. Each column goes out as a run of bit-planes followed by a one-cycle latch strobe that names the column. Once the last column is latched it wraps to the first, so every stored coupling is rewritten regularly and charge held in the analog array never drifts far.

The same refresh cadence drives a perturbation scheme. A programmable period timer opens windows of programmable length. At each column boundary that falls inside a window, the per-column gate outputs take the value of a column mask. A raised gate switches the bias of that column's converters off, which forces those couplings to zero. The shift link always carries the stored values, so the first boundary after a window closes drops the gates and the programmed problem is back in force. A period of zero turns perturbation off.

The host writes single coefficients at any time. A write to the column that is being shifted lands on that column's next refresh. The busy output is high from the start pulse until the first full pass over the matrix has been latched, and refresh then continues on its own.

Top module: `coupling_refresh_ctrl`

## Requirements
- R1: While reset is held and after reset until a start pulse, busy, sh_en and latch are 0 and col_gate is all zeros.
- R2: A start pulse in the idle state raises busy in the next cycle. Busy falls in the cycle after the latch strobe of column N_COLS-1 in the first pass, and refresh continues without a further start.
- R3: Each column is sent as (MAG_W+1)*N_ROWS consecutive cycles with sh_en=1 and then one cycle with latch=1 and sh_en=0, with latch_col holding that column. Columns go in ascending order and wrap from N_COLS-1 to 0.
- R4: Within a column, the bit-planes go out in this order: magnitude bit 0 up to magnitude bit MAG_W-1, then the sign bit (1 = negative). Within each plane, rows go out from row 0 to row N_ROWS-1.
- R5: A coefficient written with magnitude 0 is sent with its sign bit 0, whatever sign was written.
- R6: A write to the column being shifted does not change that column's current load and appears on its next load. A write to any other column appears on that column's next load.
- R7: With period P>0 and length L (L<=P), counting the first shifting cycle after start as cycle 0, the window is open in cycle k when k>=P and k mod P < L. Latching in an open cycle sets col_gate to pert_mask. Latching in a closed cycle clears col_gate.
- R8: col_gate changes only in the cycle that follows a latch strobe.
- R9: When pert_period is 0 during a latch cycle, col_gate is all zeros after that latch.
- R10: The data sent for a gated column is its stored coefficients, so the refresh after a window writes the programmed values back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for programming and refresh |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| start | input | 1 | One-cycle pulse that begins the initial load from idle |
| wr_en | input | 1 | Host coefficient write strobe |
| wr_col | input | COL_W | Column of the coefficient being written |
| wr_row | input | ROW_W | Row of the coefficient being written |
| wr_sign | input | 1 | Sign of the written coefficient, 1 = negative |
| wr_mag | input | MAG_W | Magnitude of the written coefficient |
| pert_mask | input | N_COLS | Columns to gate during a perturbation window |
| pert_period | input | CNT_W | Cycles between window starts, 0 = off |
| pert_len | input | CNT_W | Window length in cycles |
| sh_data | output | 1 | Serial coefficient bit |
| sh_en | output | 1 | High while sh_data carries a valid bit |
| latch | output | 1 | One-cycle strobe that transfers the shifted column |
| latch_col | output | COL_W | Column index that goes with latch |
| col_gate | output | N_COLS | Per-column bias gate, 1 = forced to zero coupling |
| busy | output | 1 | High during the initial full-matrix load |

## Verification
The assertions take it that start is pulsed only while the block is idle and that the perturbation settings are held steady over the latch cycle they act on. The stimulus meets both: it starts once after each reset and changes period, length and mask only at the first shifting cycle of a column. The bench's window model also needs the window length to be no longer than the period, and the host never writes in a latch cycle, where the next column's snapshot is taken. Mid-column writes go in at a fixed shift offset, and perturbation is switched off only at a column boundary, so every expected gate value comes straight from the cycle count.

// File: rtl/coupling_refresh_pkg.sv
package coupling_refresh_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_LATCH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/coupling_coef_store.sv
module coupling_coef_store #(
    parameter int N_ROWS = 64,
    parameter int N_COLS = 64,
    parameter int MAG_W  = 4,
    parameter int ROW_W  = $clog2(N_ROWS),
    parameter int COL_W  = $clog2(N_COLS),
    parameter int PL_W   = $clog2(MAG_W + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_col,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             wr_sign,
    input  logic [MAG_W-1:0] wr_mag,
    input  logic             snap_load,
    input  logic [COL_W-1:0] snap_col,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [PL_W-1:0]  rd_plane,
    output logic             rd_bit
);
    localparam int CW = MAG_W + 1;

    // Stored word: {sign, magnitude}; zero magnitude is stored with a clear sign.
    logic [CW-1:0] mem_q  [N_COLS][N_ROWS];
    logic [CW-1:0] snap_q [N_ROWS];
    logic [CW-1:0] snap_d [N_ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_col][wr_row] <= {wr_sign & (|wr_mag), wr_mag};
        end
    end

    // Column snapshot taken at each column start, so host writes cannot tear a load.
    always_comb begin
        snap_d = snap_q;
        if (snap_load) begin
            snap_d = mem_q[snap_col];
        end
    end

    always_ff @(posedge clk) begin
        snap_q <= snap_d;
    end

    assign rd_bit = snap_q[rd_row][rd_plane];
endmodule

// File: rtl/coupling_refresh_seq.sv
module coupling_refresh_seq
    import coupling_refresh_pkg::*;
#(
    parameter int N_ROWS = 64,
    parameter int N_COLS = 64,
    parameter int PLANES = 5,
    parameter int ROW_W  = $clog2(N_ROWS),
    parameter int COL_W  = $clog2(N_COLS),
    parameter int PL_W   = $clog2(PLANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             shift_en,
    output logic [ROW_W-1:0] row,
    output logic [PL_W-1:0]  plane,
    output logic             latch,
    output logic [COL_W-1:0] col,
    output logic             busy,
    output logic             running,
    output logic             snap_load,
    output logic [COL_W-1:0] snap_col
);
    typedef struct packed {
        seq_state_e       st;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [PL_W-1:0]  plane;
        logic             busy;
    } seq_t;

    seq_t s_q, s_d;
    logic [COL_W-1:0] col_next;

    always_comb begin
        s_d       = s_q;
        snap_load = 1'b0;
        snap_col  = '0;
        col_next  = (s_q.col == COL_W'(N_COLS - 1)) ? '0 : s_q.col + 1'b1;
        case (s_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.st    = SEQ_SHIFT;
                    s_d.col   = '0;
                    s_d.row   = '0;
                    s_d.plane = '0;
                    s_d.busy  = 1'b1;
                    snap_load = 1'b1;
                end
            end
            SEQ_SHIFT: begin
                if (s_q.row == ROW_W'(N_ROWS - 1)) begin
                    s_d.row = '0;
                    if (s_q.plane == PL_W'(PLANES - 1)) begin
                        s_d.plane = '0;
                        s_d.st    = SEQ_LATCH;
                    end else begin
                        s_d.plane = s_q.plane + 1'b1;
                    end
                end else begin
                    s_d.row = s_q.row + 1'b1;
                end
            end
            SEQ_LATCH: begin
                s_d.st    = SEQ_SHIFT;
                s_d.col   = col_next;
                snap_load = 1'b1;
                snap_col  = col_next;
                if (s_q.col == COL_W'(N_COLS - 1)) begin
                    s_d.busy = 1'b0;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, col: '0, row: '0, plane: '0, busy: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign shift_en = (s_q.st == SEQ_SHIFT);
    assign latch    = (s_q.st == SEQ_LATCH);
    assign running  = (s_q.st != SEQ_IDLE);
    assign row      = s_q.row;
    assign plane    = s_q.plane;
    assign col      = s_q.col;
    assign busy     = s_q.busy;
endmodule

// File: rtl/coupling_perturb_timer.sv
module coupling_perturb_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] len,
    output logic             active
);
    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] act;
    } tmr_t;

    tmr_t t_q, t_d;
    logic trig;

    always_comb begin
        t_d  = t_q;
        trig = 1'b0;
        if (!run || (period == '0)) begin
            t_d.per = '0;
            t_d.act = '0;
        end else begin
            trig    = (t_q.per == period - 1'b1);
            t_d.per = trig ? '0 : t_q.per + 1'b1;
            if (trig) begin
                t_d.act = len;
            end else if (t_q.act != '0) begin
                t_d.act = t_q.act - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign active = (t_q.act != '0) && (period != '0);
endmodule

// File: rtl/coupling_refresh_ctrl.sv
module coupling_refresh_ctrl #(
    parameter int N_ROWS = 64,
    parameter int N_COLS = 64,
    parameter int MAG_W  = 4,
    parameter int CNT_W  = 32,
    parameter int ROW_W  = $clog2(N_ROWS),
    parameter int COL_W  = $clog2(N_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic              wr_sign,
    input  logic [MAG_W-1:0]  wr_mag,
    input  logic [N_COLS-1:0] pert_mask,
    input  logic [CNT_W-1:0]  pert_period,
    input  logic [CNT_W-1:0]  pert_len,
    output logic              sh_data,
    output logic              sh_en,
    output logic              latch,
    output logic [COL_W-1:0]  latch_col,
    output logic [N_COLS-1:0] col_gate,
    output logic              busy
);
    localparam int PLANES = MAG_W + 1;
    localparam int PL_W   = $clog2(PLANES);

    logic             shift_en, latch_w, running, snap_load, rd_bit, pert_active;
    logic [ROW_W-1:0] row;
    logic [PL_W-1:0]  plane;
    logic [COL_W-1:0] col, snap_col;

    coupling_refresh_seq #(
        .N_ROWS(N_ROWS), .N_COLS(N_COLS), .PLANES(PLANES),
        .ROW_W(ROW_W), .COL_W(COL_W), .PL_W(PL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .shift_en(shift_en), .row(row), .plane(plane),
        .latch(latch_w), .col(col), .busy(busy), .running(running),
        .snap_load(snap_load), .snap_col(snap_col)
    );

    coupling_coef_store #(
        .N_ROWS(N_ROWS), .N_COLS(N_COLS), .MAG_W(MAG_W),
        .ROW_W(ROW_W), .COL_W(COL_W), .PL_W(PL_W)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_col(wr_col), .wr_row(wr_row),
        .wr_sign(wr_sign), .wr_mag(wr_mag),
        .snap_load(snap_load), .snap_col(snap_col),
        .rd_row(row), .rd_plane(plane), .rd_bit(rd_bit)
    );

    coupling_perturb_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(running),
        .period(pert_period), .len(pert_len), .active(pert_active)
    );

    // Gate register: retimed only at the column boundary.
    logic [N_COLS-1:0] gate_q, gate_d;

    always_comb begin
        gate_d = gate_q;
        if (latch_w) begin
            gate_d = pert_active ? pert_mask : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign sh_en     = shift_en;
    assign sh_data   = shift_en & rd_bit;
    assign latch     = latch_w;
    assign latch_col = col;
    assign col_gate  = gate_q;
endmodule

// File: rtl/coupling_refresh_chk.sv
module coupling_refresh_chk #(
    parameter int N_ROWS = 64,
    parameter int N_COLS = 64,
    parameter int MAG_W  = 4,
    parameter int CNT_W  = 32,
    parameter int COL_W  = $clog2(N_COLS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sh_en,
    input logic              latch,
    input logic [COL_W-1:0]  latch_col,
    input logic [N_COLS-1:0] col_gate,
    input logic [CNT_W-1:0]  pert_period,
    input logic              busy
);
    localparam int RUN   = (MAG_W + 1) * N_ROWS;
    localparam int RUN_W = $clog2(RUN + 1) + 1;

    logic [RUN_W-1:0] shift_cnt;
    logic [COL_W-1:0] prev_col;
    logic             seen_latch;
    logic [COL_W-1:0] want_col;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_cnt  <= '0;
            prev_col   <= '0;
            seen_latch <= 1'b0;
        end else begin
            if (latch) begin
                shift_cnt  <= '0;
                prev_col   <= latch_col;
                seen_latch <= 1'b1;
            end else if (sh_en) begin
                shift_cnt <= shift_cnt + 1'b1;
            end
        end
    end

    assign want_col = (prev_col == COL_W'(N_COLS - 1)) ? '0 : prev_col + 1'b1;

    AST_LATCH_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch && sh_en)); // R3
    AST_SHIFT_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> (shift_cnt == RUN_W'(RUN))); // R3
    AST_COL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && seen_latch) |-> (latch_col == want_col)); // R3
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(latch) |-> $stable(col_gate)); // R8
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(latch) && ($past(latch_col) == COL_W'(N_COLS - 1)))); // R2
    AST_NO_PERIOD_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(latch) && ($past(pert_period) == '0)) |-> (col_gate == '0)); // R9
endmodule

bind coupling_refresh_ctrl coupling_refresh_chk #(
    .N_ROWS(N_ROWS), .N_COLS(N_COLS), .MAG_W(MAG_W), .CNT_W(CNT_W), .COL_W(COL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sh_en(sh_en), .latch(latch),
    .latch_col(latch_col), .col_gate(col_gate),
    .pert_period(pert_period), .busy(busy)
);

// File: tb/coupling_refresh_ctrl_tb.sv
module coupling_refresh_ctrl_tb;
    localparam int CLK_PERIOD = 12;
    localparam int NR   = 4;
    localparam int NC   = 4;
    localparam int MW   = 4;
    localparam int CW   = 8;
    localparam int ROWW = $clog2(NR);
    localparam int COLW = $clog2(NC);
    localparam int RUN  = (MW + 1) * NR;
    localparam int CPC  = RUN + 1;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic            rst_n, start, wr_en, wr_sign;
    logic [COLW-1:0] wr_col;
    logic [ROWW-1:0] wr_row;
    logic [MW-1:0]   wr_mag;
    logic [NC-1:0]   pert_mask;
    logic [CW-1:0]   pert_period, pert_len;
    logic            sh_data, sh_en, latch, busy;
    logic [COLW-1:0] latch_col;
    logic [NC-1:0]   col_gate;

    coupling_refresh_ctrl #(.N_ROWS(NR), .N_COLS(NC), .MAG_W(MW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_col(wr_col), .wr_row(wr_row), .wr_sign(wr_sign), .wr_mag(wr_mag),
        .pert_mask(pert_mask), .pert_period(pert_period), .pert_len(pert_len),
        .sh_data(sh_data), .sh_en(sh_en), .latch(latch), .latch_col(latch_col),
        .col_gate(col_gate), .busy(busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int exp_mag [NC][NR];
    bit exp_sgn [NC][NR];
    int k;
    int cur_p, cur_l;
    logic [NC-1:0] cur_mask;
    logic [NC-1:0] exp_gate;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wr_coef(input int c, input int r, input bit s, input int m);
        wr_en   = 1'b1;
        wr_col  = COLW'(c);
        wr_row  = ROWW'(r);
        wr_sign = s;
        wr_mag  = MW'(m);
        exp_mag[c][r] = m;
        exp_sgn[c][r] = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill(input int q);
        for (int c = 0; c < NC; c++) begin
            for (int r = 0; r < NR; r++) begin
                int code;
                code = (c * NR + r + q * 16) % 32;
                wr_coef(c, r, code[4], code % 16);
            end
        end
    endtask

    function automatic bit win_open(input int kk);
        if (cur_p == 0) return 1'b0;
        return (kk >= cur_p) && ((kk % cur_p) < cur_l);
    endfunction

    // Entered at the negedge of the first shifting cycle of a column.
    task automatic run_column(input int pass, input int col, input string tag,
                              input bit inj, input int ic, input int ir,
                              input bit is, input int im);
        int sm [NR];
        bit ss [NR];
        int gm [NR];
        bit gs [NR];
        int bad_en;
        bit was_gated;
        logic [NC-1:0] next_gate;
        next_gate = exp_gate;
        was_gated = exp_gate[col];
        bad_en = 0;
        for (int r = 0; r < NR; r++) begin
            sm[r] = exp_mag[col][r];
            ss[r] = exp_sgn[col][r];
            gm[r] = 0;
            gs[r] = 1'b0;
        end
        for (int i = 0; i < CPC; i++) begin
            if (i < RUN) begin
                int pl, rw;
                pl = i / NR;
                rw = i % NR;
                if (!sh_en) bad_en++;
                if (pl < MW) gm[rw] = gm[rw] | (int'(sh_data) << pl);
                else gs[rw] = sh_data;
            end
            if (i == 0) begin
                check(col_gate == exp_gate, (cur_p == 0) ? "R9 gate" : "R7 gate",
                      int'(col_gate), int'(exp_gate));
                check(busy == (pass == 0), "R2 busy", int'(busy), int'(pass == 0));
            end
            if (i == RUN) begin
                check(latch == 1'b1 && sh_en == 1'b0, "R3 latch strobe",
                      int'(latch), 1);
                check(latch_col == COLW'(col), "R3 latch_col", int'(latch_col), col);
                check(col_gate == exp_gate, "R8 gate held mid-column",
                      int'(col_gate), int'(exp_gate));
                next_gate = win_open(k) ? cur_mask : '0;
            end
            if (inj && i == 3) begin
                wr_en   = 1'b1;
                wr_col  = COLW'(ic);
                wr_row  = ROWW'(ir);
                wr_sign = is;
                wr_mag  = MW'(im);
                exp_mag[ic][ir] = im;
                exp_sgn[ic][ir] = is;
            end
            if (inj && i == 4) wr_en = 1'b0;
            @(negedge clk);
            k++;
        end
        check(bad_en == 0, "R3 shift run", bad_en, 0);
        for (int r = 0; r < NR; r++) begin
            bit es;
            string t;
            es = ss[r] && (sm[r] != 0);
            if (was_gated) t = "R10";
            else if (ss[r] && sm[r] == 0) t = "R5";
            else t = tag;
            check(gm[r] == sm[r], {t, " magnitude"}, gm[r], sm[r]);
            check(gs[r] == es, {t, " sign"}, int'(gs[r]), int'(es));
        end
        exp_gate = next_gate;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        exp_gate = '0;
    endtask

    task automatic check_idle(input string req);
        check(busy == 1'b0, {req, " busy"}, int'(busy), 0);
        check(sh_en == 1'b0, {req, " sh_en"}, int'(sh_en), 0);
        check(latch == 1'b0, {req, " latch"}, int'(latch), 0);
        check(col_gate == '0, {req, " col_gate"}, int'(col_gate), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; wr_sign = 1'b0;
        wr_col = '0; wr_row = '0; wr_mag = '0;
        pert_mask = '0; pert_period = '0; pert_len = '0;
        cur_p = 0; cur_l = 0; cur_mask = '0; exp_gate = '0; k = 0;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 after reset");

        // Phase A: perturbation off with a full mask, codes 0..15.
        fill(0);
        pert_mask = '1; cur_mask = '1;
        check_idle("R1 before start");
        do_start();
        for (int c = 0; c < NC; c++) run_column(0, c, "R4", 1'b0, 0, 0, 1'b0, 0);
        run_column(1, 0, "R4", 1'b0, 0, 0, 1'b0, 0);
        run_column(1, 1, "R6", 1'b1, 3, 0, 1'b1, 9);
        run_column(1, 2, "R6", 1'b1, 2, 1, 1'b0, 7);
        run_column(1, 3, "R6", 1'b0, 0, 0, 1'b0, 0);
        for (int c = 0; c < NC; c++) run_column(2, c, "R6", 1'b0, 0, 0, 1'b0, 0);

        // Phase B: codes 16..31, perturbation windows.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R1 second reset");
        rst_n = 1'b1;
        @(negedge clk);
        fill(1);
        pert_mask = 4'b0110; cur_mask = 4'b0110;
        pert_period = 8'd50; cur_p = 50;
        pert_len = 8'd30; cur_l = 30;
        do_start();
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < NC; c++) run_column(p, c, "R7", 1'b0, 0, 0, 1'b0, 0);
        end
        pert_period = '0; cur_p = 0;
        for (int p = 4; p < 6; p++) begin
            for (int c = 0; c < NC; c++) run_column(p, c, "R9", 1'b0, 0, 0, 1'b0, 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule